// File: doc/BRIEF.md
# Boot Configuration Word Sequencer

This block runs once after a start pulse and works through a table of 32-bit configuration words kept in a boot buffer, such as the first sector copied from a memory card. It fetches words through a request/valid read port, beginning at byte offset 0x80. The table holds 8-byte entries. Each entry is an address word followed by a data word.

The lowest bit of the address word picks what the entry means. When it is clear, the entry is a register write: the address word and the data word go out together on a write port that waits for the downstream ready. When it is set, the entry is a control word, and exactly one of its two top bits must be set. One top bit asks for a pause of eight clocks per unit of the data word. The other top bit ends the sequence, and the data word of that final entry is never fetched.

After a terminator the block raises a done flag, which tells the next stage to start copying user code. A malformed control word stops the block with an error flag raised. Running past an entry limit without finding a terminator does the same. In both cases the block issues nothing more until the next start pulse.

Top module: `boot_cfg_seq`

## Requirements
- R1: While reset is high and in the cycle after it, rd_req, wr_valid, busy, done and err are all low.
- R2: After start, the first word is read at byte address 0x80. Each later read is at the previous read address plus 4, and rd_addr bits [1:0] are always 00.
- R3: An address word with bit 0 clear makes one write. Its wr_addr is the address word and its wr_data is the data word that follows it. No write is made for any other entry.
- R4: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_addr and wr_data do not change. A write completes in the cycle where both are high.
- R5: While rd_req is high and rd_valid is low, rd_req stays high and rd_addr does not change. A read completes in the cycle where both are high.
- R6: A word with bit 0 set, bit 30 set, bit 31 clear and bits 29..1 clear is a delay. Let N be the data word it reads and let t be the cycle in which that data returns. The next address-word request rises exactly 8·N+2 cycles after t. No read or write is active in between, and N = 0 gives the minimum gap of 2.
- R7: A word with bit 0 set, bit 31 set, bit 30 clear and bits 29..1 clear ends the sequence. Done rises in the next cycle and busy falls. The word after it is not read, and no further read or write follows.
- R8: A word with bit 0 set is illegal in three cases: bits 31 and 30 are both set, both are clear, or any of bits 29..1 is set. Err rises in the next cycle, and no data word and no further read or write follows.
- R9: MAX_ENTRIES address words may be fetched in one run, with 0 meaning no limit. If all of them have been handled and none was a terminator, err rises in the cycle in which the next read would have started, and no read is made.
- R10: Start is taken when the block is idle, done or in error. It clears done and err and restarts at 0x80. A start while busy has no effect on the read or write sequence.
- R11: Done and err are never high together, and busy is low whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; re-arms the walk at offset 0x80 |
| rd_req | output | 1 | Word read request, held until rd_valid |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data return, completes the pending request |
| rd_data | input | WORD_W | Returned word |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | WORD_W | Register write address (the address word) |
| wr_data | output | WORD_W | Register write data (the data word) |
| wr_ready | input | 1 | Downstream accepts the write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Terminator reached; user code copy may start |
| err | output | 1 | Walk stopped on a malformed word or the entry limit |

## Verification
The bench builds the block with ADDR_W = 10 and MAX_ENTRIES = 6. With a limit of six, a table that has no terminator reaches the limit error after only a few entries. A terminator placed in the sixth slot checks the boundary from the other side. The read latency is varied from one to three cycles and the write-ready pattern is set per table, so back-to-back reads and stalled writes both occur. Delay values of 0, 1, 3 and 20 check the 8·N+2 gap, including a start pulse that arrives while the block is waiting out a delay.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_A,
    S_FETCH_D,
    S_WRITE,
    S_WAIT,
    S_DONE,
    S_ERROR
  } seq_state_t;

  typedef struct packed {
    logic ctrl;  // word is a control word
    logic fin;   // legal terminator
    logic dly;   // legal delay
    logic bad;   // malformed control word
  } cmd_t;

endpackage

// File: rtl/boot_cfg_decode.sv
module boot_cfg_decode
  import boot_cfg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output cmd_t              cmd
);

  localparam int FIN_POS = WORD_W - 1;
  localparam int DLY_POS = WORD_W - 2;
  localparam int RSV_TOP = WORD_W - 3;

  logic rsv_set;
  logic one_op;

  assign rsv_set = |word[RSV_TOP:1];
  assign one_op  = word[FIN_POS] ^ word[DLY_POS];

  always_comb begin
    cmd.ctrl = word[0];
    cmd.bad  = word[0] & (rsv_set | ~one_op);
    cmd.fin  = word[0] & ~cmd.bad & word[FIN_POS];
    cmd.dly  = word[0] & ~cmd.bad & word[DLY_POS];
  end

  // R8: a legal control word never selects both operations
  always_comb begin
    a_r8_one_op : assert (!(cmd.fin && cmd.dly));
  end

endmodule

// File: rtl/boot_cfg_timer.sv
module boot_cfg_timer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ticks,
  output logic              expired
);

  localparam int CNT_W = DATA_W + 3;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= {ticks, 3'b000};
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

  // R6: the delay counter falls by one per clock until it reaches zero
  a_r6_count_down : assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/boot_cfg_wrport.sv
module boot_cfg_wrport #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] addr,
  output logic [WORD_W-1:0] data,
  output logic              accept
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign accept = valid & ready;

  // R4: a stalled write keeps its request and its payload
  a_r4_wr_hold : assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));

endmodule

// File: rtl/boot_cfg_seq.sv
module boot_cfg_seq
  import boot_cfg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORD_W      = 32,
  parameter int BASE_OFS    = 128,
  parameter int MAX_ENTRIES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int IDX_W = (MAX_ENTRIES > 0) ? $clog2(MAX_ENTRIES + 1) : 1;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE_OFS);

  seq_state_t        state;
  cmd_t              cmd;
  logic              pend_dly;
  logic [WORD_W-1:0] pend_addr;
  logic              wr_accept;
  logic              tmr_expired;
  logic              limit_hit;
  logic              can_start;
  logic              fetch_a_done;
  logic              fetch_d_done;
  logic              step;
  logic              wr_load;
  logic              tmr_load;

  boot_cfg_decode #(.WORD_W(WORD_W)) u_decode (
    .word (rd_data),
    .cmd  (cmd)
  );

  assign can_start    = start && (state == S_IDLE || state == S_DONE || state == S_ERROR);
  assign fetch_a_done = (state == S_FETCH_A) && rd_valid;
  assign fetch_d_done = (state == S_FETCH_D) && rd_valid;
  assign wr_load      = fetch_d_done && !pend_dly;
  assign tmr_load     = fetch_d_done && pend_dly;
  assign step         = ((state == S_WRITE) && wr_accept) ||
                        ((state == S_WAIT) && tmr_expired);

  boot_cfg_wrport #(.WORD_W(WORD_W)) u_wrport (
    .clk     (clk),
    .rst     (rst),
    .load    (wr_load),
    .ld_addr (pend_addr),
    .ld_data (rd_data),
    .ready   (wr_ready),
    .valid   (wr_valid),
    .addr    (wr_addr),
    .data    (wr_data),
    .accept  (wr_accept)
  );

  boot_cfg_timer #(.DATA_W(WORD_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .ticks   (rd_data),
    .expired (tmr_expired)
  );

  generate
    if (MAX_ENTRIES > 0) begin : g_limit
      logic [IDX_W-1:0] idx;
      always_ff @(posedge clk) begin
        if (rst) begin
          idx <= '0;
        end else if (can_start) begin
          idx <= '0;
        end else if (fetch_a_done) begin
          idx <= idx + IDX_W'(1);
        end
      end
      assign limit_hit = (idx == IDX_W'(MAX_ENTRIES));
    end else begin : g_nolimit
      assign limit_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      pend_dly  <= 1'b0;
      pend_addr <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERROR: begin
          if (start) begin
            state   <= S_FETCH_A;
            rd_req  <= 1'b1;
            rd_addr <= FIRST;
            busy    <= 1'b1;
            done    <= 1'b0;
            err     <= 1'b0;
          end
        end
        S_FETCH_A: begin
          if (rd_valid) begin
            if (cmd.bad) begin
              state  <= S_ERROR;
              rd_req <= 1'b0;
              busy   <= 1'b0;
              err    <= 1'b1;
            end else if (cmd.fin) begin
              state  <= S_DONE;
              rd_req <= 1'b0;
              busy   <= 1'b0;
              done   <= 1'b1;
            end else begin
              state     <= S_FETCH_D;
              rd_addr   <= rd_addr + STEP;
              pend_dly  <= cmd.dly;
              pend_addr <= rd_data;
            end
          end
        end
        S_FETCH_D: begin
          if (rd_valid) begin
            rd_req  <= 1'b0;
            rd_addr <= rd_addr + STEP;
            state   <= pend_dly ? S_WAIT : S_WRITE;
          end
        end
        S_WRITE, S_WAIT: begin
          if (step) begin
            if (limit_hit) begin
              state <= S_ERROR;
              busy  <= 1'b0;
              err   <= 1'b1;
            end else begin
              state  <= S_FETCH_A;
              rd_req <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: reset leaves every handshake and flag low
  a_r1_reset_quiet : assert property (@(posedge clk)
    rst |=> (!rd_req && !wr_valid && !busy && !done && !err));

  // R5: a pending read keeps its request and address
  a_r5_rd_hold : assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R2: reads are word aligned
  a_r2_word_align : assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  // R6: nothing is requested while a delay runs
  a_r6_wait_quiet : assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (!rd_req && !wr_valid));

  // R7: after the terminator the ports stay silent
  a_r7_done_quiet : assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_req && !wr_valid));

  // R8: after an error the ports stay silent
  a_r8_err_quiet : assert property (@(posedge clk) disable iff (rst)
    err |-> (!rd_req && !wr_valid));

  // R11: terminal flags are exclusive and clear busy
  a_r11_flag_excl : assert property (@(posedge clk) disable iff (rst)
    done |-> !err);

  a_r11_flag_idle : assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy);

  // R10: a start pulse while busy does not restart the read address
  a_r10_busy_start : assert property (@(posedge clk) disable iff (rst)
    (busy && start && rd_req && !rd_valid) |=> $stable(rd_addr));

endmodule

// File: tb/boot_cfg_seq_test.sv
`timescale 1ns/1ps
module boot_cfg_seq_test;

  localparam int AW   = 10;
  localparam int MAXE = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          wr_valid;
  logic [31:0]   wr_addr;
  logic [31:0]   wr_data;
  logic          wr_ready;
  logic          busy, done, err;

  always #2 clk = ~clk;

  boot_cfg_seq #(.ADDR_W(AW), .WORD_W(32), .BASE_OFS(128), .MAX_ENTRIES(MAXE)) uut (
    .clk(clk), .rst(rst), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done), .err(err)
  );

  // boot buffer with variable read latency
  logic [31:0]   mem [0:255];
  int            lat_cfg = 1;
  int            lat_cnt;
  logic          mem_busy;
  logic [AW-1:0] mem_a;

  always @(posedge clk) begin
    if (rst) begin
      mem_busy <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (!mem_busy) begin
      rd_valid <= 1'b0;
      if (rd_req && !rd_valid) begin
        mem_busy <= 1'b1;
        mem_a    <= rd_addr;
        lat_cnt  <= lat_cfg;
      end
    end else if (lat_cnt > 1) begin
      lat_cnt <= lat_cnt - 1;
    end else begin
      rd_valid <= 1'b1;
      rd_data  <= mem[mem_a[AW-1:2]];
      mem_busy <= 1'b0;
    end
  end

  int       cyc = 0;
  logic [7:0] rdy_pat = 8'hFF;
  always @(posedge clk) cyc <= cyc + 1;
  assign wr_ready = rdy_pat[cyc % 8];

  // reference model
  typedef struct { int addr; int gap; int kind; } rd_exp_t;
  typedef struct { logic [31:0] a; logic [31:0] d; } wr_exp_t;
  rd_exp_t rq[$];
  wr_exp_t wq[$];
  int      exp_out;

  function automatic logic [31:0] rdw(int a);
    return mem[(a / 4) % 256];
  endfunction

  function automatic void walk();
    int a = 128;
    int idx = 0;
    int gap = -1;
    logic [31:0] w;
    rd_exp_t r;
    wr_exp_t x;
    rq.delete();
    wq.delete();
    forever begin
      if (MAXE > 0 && idx == MAXE) begin exp_out = 2; break; end
      w = rdw(a);
      idx++;
      r.addr = a; r.gap = gap; r.kind = 0;
      if (w[0] == 1'b0) begin
        rq.push_back(r);
        r.addr = a + 4; r.gap = -1;
        rq.push_back(r);
        x.a = w; x.d = rdw(a + 4);
        wq.push_back(x);
        gap = -1;
        a += 8;
      end else if (w[29:1] != 0 || (w[31] == w[30])) begin
        r.kind = 2; rq.push_back(r); exp_out = 2; break;
      end else if (w[31]) begin
        r.kind = 1; rq.push_back(r); exp_out = 1; break;
      end else begin
        rq.push_back(r);
        r.addr = a + 4; r.gap = -1;
        rq.push_back(r);
        gap = 8 * int'(rdw(a + 4)) + 2;
        a += 8;
      end
    end
  endfunction

  int nvec = 0;
  int nfail = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison
  int       cyc_ne = 0;
  int       last_ret = 0;
  int       meas_gap = 0;
  int       pend_flag = 0;
  logic     prev_req = 1'b0, prev_val = 1'b0;
  logic     prev_stall = 1'b0;
  logic [31:0] prev_wa, prev_wd;

  always @(negedge clk) begin
    if (!rst) begin
      rd_exp_t e;
      wr_exp_t x;
      cyc_ne++;
      if (pend_flag == 1) begin
        chk("R7", "done after terminator", {done, err}, 2'b10);
      end else if (pend_flag == 2) begin
        chk("R8", "err after illegal word", {done, err}, 2'b01);
      end
      pend_flag = 0;
      if (prev_stall)
        chk("R4", "stalled write held", {wr_valid, wr_addr, wr_data}, {1'b1, prev_wa, prev_wd});
      if (rd_req && (!prev_req || prev_val)) meas_gap = cyc_ne - last_ret;
      if (rd_req && rd_valid) begin
        if (rq.size() == 0) begin
          chk("R7", "unexpected read address", 64'(rd_addr), 64'hFFFF);
        end else begin
          e = rq.pop_front();
          chk("R2", "read address", 64'(rd_addr), 64'(e.addr));
          if (e.gap >= 0) chk("R6", "delay gap", 64'(meas_gap), 64'(e.gap));
          pend_flag = e.kind;
        end
        last_ret = cyc_ne;
      end
      if (wr_valid && wr_ready) begin
        if (wq.size() == 0) begin
          chk("R3", "unexpected write", {wr_addr, wr_data}, 64'h0);
        end else begin
          x = wq.pop_front();
          chk("R3", "write pair", {wr_addr, wr_data}, {x.a, x.d});
        end
      end
      chk("R11", "flags", {done && err, (done || err) && busy}, 2'b00);
      prev_stall = wr_valid && !wr_ready;
      prev_wa = wr_addr;
      prev_wd = wr_data;
      prev_req = rd_req;
      prev_val = rd_valid;
    end
  end

  task automatic clear_tbl();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic put(input int i, input logic [31:0] w);
    mem[32 + i] = w;
  endtask

  task automatic run_table(input string tag, input int kick);
    walk();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      start = (k == kick);
      if ((done || err) && !busy && k > kick) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(tag, "final done", 64'(done), 64'(exp_out == 1));
    chk(tag, "final err", 64'(err), 64'(exp_out == 2));
    chk(tag, "reads left", 64'(rq.size()), 64'h0);
    chk(tag, "writes left", 64'(wq.size()), 64'h0);
  endtask

  localparam logic [31:0] W_END  = 32'h8000_0001;
  localparam logic [31:0] W_DLY  = 32'h4000_0001;

  initial begin
    clear_tbl();
    repeat (4) @(negedge clk);
    chk("R1", "outputs in reset", {rd_req, wr_valid, busy, done, err}, 5'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {rd_req, wr_valid, busy, done, err}, 5'b0);

    // plain writes then terminator; word after terminator must stay unread
    put(0, 32'h0000_0100); put(1, 32'hAAAA_0001);
    put(2, 32'h0000_0204); put(3, 32'h0000_0055);
    put(4, 32'h0000_0308); put(5, 32'h0000_1234);
    put(6, W_END);         put(7, 32'hDEAD_BEEF);
    run_table("R7", -1);

    // stalls, slow reads, delays of 0 and 3
    clear_tbl(); lat_cfg = 3; rdy_pat = 8'b1001_0010;
    put(0, 32'h0000_0410); put(1, 32'h0000_0001);
    put(2, W_DLY);         put(3, 32'h0);
    put(4, 32'h0000_0414); put(5, 32'hFFFF_FFFF);
    put(6, W_DLY);         put(7, 32'h3);
    put(8, W_END);
    run_table("R6", -1);

    // both operation bits set
    clear_tbl(); lat_cfg = 2; rdy_pat = 8'hFF;
    put(0, 32'h0000_0500); put(1, 32'h0000_0077);
    put(2, 32'hC000_0001); put(3, 32'h0);
    run_table("R8", -1);

    // no operation bit set (re-arm from error)
    clear_tbl();
    put(0, 32'h0000_0001);
    run_table("R10", -1);

    // reserved bit set after a one-unit delay
    clear_tbl(); lat_cfg = 1;
    put(0, W_DLY); put(1, 32'h1);
    put(2, 32'h8000_0003);
    run_table("R8", -1);

    // six writes, no terminator: limit error
    clear_tbl(); rdy_pat = 8'b1011_0111;
    for (int i = 0; i < 6; i++) begin
      put(2 * i, 32'h0000_0600 + 32'(4 * i)); put(2 * i + 1, 32'(i * 17));
    end
    put(12, W_END);
    run_table("R9", -1);

    // terminator in the sixth slot is within the limit
    clear_tbl();
    for (int i = 0; i < 5; i++) begin
      put(2 * i, 32'h0000_0700 + 32'(4 * i)); put(2 * i + 1, 32'(i + 9));
    end
    put(10, W_END);
    run_table("R9", -1);

    // start pulse while a long delay runs is ignored
    clear_tbl(); rdy_pat = 8'hFF; lat_cfg = 2;
    put(0, 32'h0000_0800); put(1, 32'h0000_00A5);
    put(2, W_DLY);         put(3, 32'd20);
    put(4, 32'h0000_0804); put(5, 32'h0000_005A);
    put(6, W_END);
    run_table("R10", 30);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule